// File: doc/BRIEF.md
# USB Root Hub Port Power Controller

This block is the power-switching part of a USB host root hub. It owns the power status bit of each downstream port and drives one power-enable output per port. It also holds the device remote-wakeup enable. Software reaches it through a simple write port with two registers: a command word and a configuration word.

The command word carries three write-one strobes. One turns port power on, one turns port power off, and one enables remote wakeup. The configuration word selects between global switching, where every port follows the command, and per-port switching. In per-port switching, ports whose mask bit is set are exempt from the global strobes.

Port power changes must not happen in the middle of a bus transaction. When a transaction is in flight, power commands are gathered in a one-entry pending record. That record is applied in the first cycle with no transaction.

Top module: `usb_rh_pwr_ctrl`

## Requirements
- R1: After synchronous reset, all `port_pwr` bits are 0, `rd_data` bit 15 is 0 and no change is pending. Toggling `xfer_busy` with no writes leaves every port off.
- R2: In global mode (config bit 8 = 0), a command write (`wr_sel`=0) with bit 16 = 1 sets every `port_pwr` bit on the clock edge of the write.
- R3: In global mode, a command write with bit 0 = 1 clears every `port_pwr` bit on the clock edge of the write.
- R4: In per-port mode (config bit 8 = 1), command bit 16 sets only the ports whose mask bit (config bits [NUM_PORTS-1:0]) is 0. Mode and mask are those in force when the command is written.
- R5: In per-port mode, command bit 0 clears only the ports whose mask bit is 0.
- R6: A command write with bits 16 and 0 both 0 leaves `port_pwr` unchanged.
- R7: Command bit 15 = 1 sets remote-wakeup enable, read at `rd_data` bit 15 from the next cycle on. A write with bit 15 = 0 never clears it.
- R8: Every `rd_data` bit other than bit 15 reads 0. Command and config bits outside those named here have no effect.
- R9: While `xfer_busy` is 1, `port_pwr` does not change. A power command written during that time takes effect on the first clock edge at which `xfer_busy` is 0.
- R10: A command with bits 16 and 0 both 1 acts as a clear on the ports it targets.
- R11: Several power commands written during one transaction merge per port, with the latest command winning. A later set overrides an earlier clear and the reverse.
- R12: A configuration write (`wr_sel`=1) takes effect on its clock edge even while `xfer_busy` is 1. It does not alter `port_pwr` or a pending change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = command word, 1 = configuration word |
| wr_data | input | 32 | Write data |
| xfer_busy | input | 1 | A bus transaction (token through handshake) is in progress |
| port_pwr | output | NUM_PORTS | Per-port power status and power enable |
| rd_data | output | 32 | Hub status read value (bit 15 = remote-wakeup enable) |

## Verification
The assertions assume that `xfer_busy` is a clean level that is known in every cycle after reset. They also assume that no path other than this block's write port changes port power. The stimulus drives `xfer_busy` as a random level, at times held for long stretches so that several commands merge. Write data is drawn at random over the full 32 bits, so reserved positions are exercised. Inputs change only one time unit after a rising edge.

// File: rtl/usb_rh_pwr_pkg.sv
package usb_rh_pwr_pkg;

    // Command word bit positions (decoded by this block)
    localparam int CMD_SET_PWR_BIT  = 16;
    localparam int CMD_SET_WAKE_BIT = 15;
    localparam int CMD_CLR_PWR_BIT  = 0;
    // Configuration word
    localparam int CFG_MODE_BIT     = 8;
    localparam int DATA_W           = 32;

    typedef enum logic {
        SEL_CMD = 1'b0,
        SEL_CFG = 1'b1
    } reg_sel_e;

    typedef enum logic {
        MODE_GLOBAL  = 1'b0,
        MODE_PERPORT = 1'b1
    } pwr_mode_e;

    typedef struct packed {
        logic set_pwr;
        logic clr_pwr;
        logic set_wake;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [DATA_W-1:0] d);
        cmd_t c;
        c.set_pwr  = d[CMD_SET_PWR_BIT];
        c.clr_pwr  = d[CMD_CLR_PWR_BIT];
        c.set_wake = d[CMD_SET_WAKE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/rh_cmd_decode.sv
module rh_cmd_decode
    import usb_rh_pwr_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 cmd_wr_i,
    input  logic [DATA_W-1:0]    data_i,
    input  pwr_mode_e            mode_i,
    input  logic [NUM_PORTS-1:0] mask_i,
    output logic [NUM_PORTS-1:0] set_vec_o,
    output logic [NUM_PORTS-1:0] clr_vec_o,
    output logic                 wake_o
);
    cmd_t                 cmd;
    logic [NUM_PORTS-1:0] target;

    always_comb begin
        cmd = unpack_cmd(data_i);
        for (int p = 0; p < NUM_PORTS; p++) begin
            target[p] = (mode_i == MODE_GLOBAL) ? 1'b1 : ~mask_i[p];
        end
        clr_vec_o = (cmd_wr_i && cmd.clr_pwr) ? target : '0;
        // clear takes precedence when both strobes are written
        set_vec_o = (cmd_wr_i && cmd.set_pwr && !cmd.clr_pwr) ? target : '0;
        wake_o    = cmd_wr_i && cmd.set_wake;
    end

    // R10: set and clear never target the same port
    always_comb begin
        assert_set_clr_disjoint_R10: assert ((set_vec_o & clr_vec_o) == '0);
    end

endmodule

// File: rtl/rh_pend_merge.sv
module rh_pend_merge #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold_i,
    input  logic [NUM_PORTS-1:0] set_i,
    input  logic [NUM_PORTS-1:0] clr_i,
    input  logic [NUM_PORTS-1:0] pwr_q_i,
    output logic [NUM_PORTS-1:0] pwr_d_o
);
    logic [NUM_PORTS-1:0] pend_set_q, pend_clr_q;
    logic [NUM_PORTS-1:0] pend_set_d, pend_clr_d;
    logic [NUM_PORTS-1:0] drained;

    always_comb begin
        // newest command wins per port
        pend_set_d = (pend_set_q & ~clr_i) | set_i;
        pend_clr_d = (pend_clr_q & ~set_i) | clr_i;
        drained    = (pwr_q_i & ~pend_clr_q) | pend_set_q;
        drained    = (drained & ~clr_i) | set_i;
        pwr_d_o    = hold_i ? pwr_q_i : drained;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_set_q <= '0;
            pend_clr_q <= '0;
        end else if (hold_i) begin
            pend_set_q <= pend_set_d;
            pend_clr_q <= pend_clr_d;
        end else begin
            pend_set_q <= '0;
            pend_clr_q <= '0;
        end
    end

    // R11: a port is never pending both on and off
    assert_pend_disjoint_R11: assert property (@(posedge clk) disable iff (rst)
        (pend_set_q & pend_clr_q) == '0);

    // R9: an idle cycle drains the pending record
    assert_pend_drain_R9: assert property (@(posedge clk) disable iff (rst)
        !hold_i |=> (pend_set_q == '0 && pend_clr_q == '0));

endmodule

// File: rtl/usb_rh_pwr_ctrl.sv
module usb_rh_pwr_ctrl
    import usb_rh_pwr_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [31:0]          wr_data,
    input  logic                 xfer_busy,
    output logic [NUM_PORTS-1:0] port_pwr,
    output logic [31:0]          rd_data
);
    pwr_mode_e            mode_q;
    logic [NUM_PORTS-1:0] mask_q;
    logic [NUM_PORTS-1:0] pwr_q, pwr_d;
    logic [NUM_PORTS-1:0] set_vec, clr_vec;
    logic                 wake_q, wake_hit;
    logic                 cmd_wr, cfg_wr;

    assign cmd_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD);
    assign cfg_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CFG);

    rh_cmd_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .cmd_wr_i (cmd_wr),
        .data_i   (wr_data),
        .mode_i   (mode_q),
        .mask_i   (mask_q),
        .set_vec_o(set_vec),
        .clr_vec_o(clr_vec),
        .wake_o   (wake_hit)
    );

    rh_pend_merge #(.NUM_PORTS(NUM_PORTS)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .hold_i (xfer_busy),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pwr_q_i(pwr_q),
        .pwr_d_o(pwr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q  <= '0;
            wake_q <= 1'b0;
            mode_q <= MODE_GLOBAL;
            mask_q <= '0;
        end else begin
            pwr_q <= pwr_d;
            if (wake_hit) wake_q <= 1'b1;
            if (cfg_wr) begin
                mode_q <= pwr_mode_e'(wr_data[CFG_MODE_BIT]);
                mask_q <= wr_data[NUM_PORTS-1:0];
            end
        end
    end

    assign port_pwr = pwr_q;

    always_comb begin
        rd_data                   = '0;
        rd_data[CMD_SET_WAKE_BIT] = wake_q;
    end

    // R9: no power change while a transaction is in flight
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        xfer_busy |=> $stable(port_pwr));

    // R7: wakeup enable only rises after a wakeup strobe and never falls
    assert_wake_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_q) |-> $past(wr_en && !wr_sel && wr_data[CMD_SET_WAKE_BIT]));
    assert_wake_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> wake_q);

    // R10/R3: idle global-mode write with both strobes leaves all ports off
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !xfer_busy && mode_q == MODE_GLOBAL
         && wr_data[CMD_SET_PWR_BIT] && wr_data[CMD_CLR_PWR_BIT])
        |=> port_pwr == '0);

endmodule

// File: tb/usb_rh_pwr_ctrl_tb.sv
module usb_rh_pwr_ctrl_tb;
    localparam int  NP      = 4;
    localparam time CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, wr_sel, xfer_busy;
    logic [31:0]   wr_data;
    logic [NP-1:0] port_pwr;
    logic [31:0]   rd_data;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // bench model
    logic [NP-1:0] m_pwr, m_ps, m_pc, m_mask;
    logic          m_mode, m_wake;

    always #(CLK_PER/2) clk = ~clk;

    usb_rh_pwr_ctrl #(.NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .xfer_busy(xfer_busy),
        .port_pwr(port_pwr), .rd_data(rd_data)
    );

    function automatic logic [NP-1:0] tgt(input logic mode, input logic [NP-1:0] mask);
        return mode ? ~mask : {NP{1'b1}};
    endfunction

    function automatic logic [31:0] exp_rd(input logic wake);
        logic [31:0] r = '0;
        r[15] = wake;
        return r;
    endfunction

    task automatic model_edge(input logic we, input logic sel, input logic [31:0] d,
                              input logic busy);
        logic [NP-1:0] s, c, t;
        s = '0; c = '0;
        t = tgt(m_mode, m_mask);
        if (we && !sel) begin
            if (d[0]) c = t;
            if (d[16]) s = t & ~c;
            if (d[15]) m_wake = 1'b1;
        end
        if (busy) begin
            m_ps = (m_ps & ~c) | s;
            m_pc = (m_pc & ~s) | c;
        end else begin
            m_pwr = (m_pwr & ~m_pc) | m_ps;
            m_pwr = (m_pwr & ~c) | s;
            m_ps = '0; m_pc = '0;
        end
        if (we && sel) begin
            m_mode = d[8];
            m_mask = d[NP-1:0];
        end
    endtask

    task automatic check(input string tag);
        vectors++;
        if (port_pwr !== m_pwr) begin
            miscompares++;
            $display("FAIL %s port_pwr actual=%b expected=%b", tag, port_pwr, m_pwr);
        end
        vectors++;
        if (rd_data !== exp_rd(m_wake)) begin
            miscompares++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_rd(m_wake));
        end
    endtask

    // drive one cycle, update the model at the edge, then compare
    task automatic cyc(input logic we, input logic sel, input logic [31:0] d,
                       input logic busy, input string tag);
        wr_en = we; wr_sel = sel; wr_data = d; xfer_busy = busy;
        @(posedge clk);
        model_edge(we, sel, d, busy);
        #1;
        wr_en = 1'b0;
        check(tag);
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; xfer_busy = 1'b0;
        m_pwr = '0; m_ps = '0; m_pc = '0; m_mask = '0; m_mode = 1'b0; m_wake = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 reset");
        cyc(1'b0, 1'b0, '0, 1'b1, "R1 idle busy");
        cyc(1'b0, 1'b0, '0, 1'b0, "R1 idle");

        // global mode
        cyc(1'b1, 1'b0, 32'h0001_0000, 1'b0, "R2 global set");
        cyc(1'b1, 1'b0, 32'hfffe_7ffe, 1'b0, "R6 zero strobes with reserved bits");
        cyc(1'b1, 1'b0, 32'h0000_0001, 1'b0, "R3 global clear");
        cyc(1'b1, 1'b0, 32'h0001_0000, 1'b0, "R2 global set again");
        cyc(1'b1, 1'b0, 32'h0001_0001, 1'b0, "R10 both strobes");
        cyc(1'b1, 1'b0, 32'h0000_8000, 1'b0, "R7 wake set");
        cyc(1'b1, 1'b0, 32'h0000_0000, 1'b0, "R7 wake write zero");
        cyc(1'b1, 1'b0, 32'h7ffe_7ffe, 1'b0, "R8 reserved bits");

        // per-port mode, mask ports 0 and 2
        cyc(1'b1, 1'b1, 32'h0000_0105, 1'b0, "R12 config per-port");
        cyc(1'b1, 1'b0, 32'h0001_0000, 1'b0, "R4 per-port set");
        cyc(1'b1, 1'b1, 32'h0000_0103, 1'b0, "R12 config new mask");
        cyc(1'b1, 1'b0, 32'h0000_0001, 1'b0, "R5 per-port clear");

        // postponement and merge
        cyc(1'b1, 1'b1, 32'h0000_0000, 1'b0, "R12 back to global");
        cyc(1'b1, 1'b0, 32'h0001_0000, 1'b1, "R9 set while busy");
        cyc(1'b0, 1'b0, '0, 1'b1, "R9 still busy");
        cyc(1'b1, 1'b0, 32'h0000_0001, 1'b1, "R11 clear overrides pending set");
        cyc(1'b1, 1'b1, 32'h0000_010f, 1'b1, "R12 config during busy");
        cyc(1'b0, 1'b0, '0, 1'b0, "R9 drain");
        cyc(1'b1, 1'b1, 32'h0000_010c, 1'b0, "R12 mask high ports");
        cyc(1'b1, 1'b0, 32'h0001_0000, 1'b1, "R11 set pending");
        cyc(1'b1, 1'b1, 32'h0000_0000, 1'b1, "R12 mode change busy");
        cyc(1'b1, 1'b0, 32'h0000_0001, 1'b1, "R11 clear all pending");
        cyc(1'b0, 1'b0, '0, 1'b0, "R11 drain merged");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic we, sel, busy;
            logic [31:0] d;
            we   = ($urandom % 2) == 0;
            sel  = ($urandom % 5) == 0;
            busy = ($urandom % 10) < ((i / 200) % 2 == 0 ? 3 : 8);
            d    = $urandom;
            if (($urandom % 4) != 0) d[15] = 1'b0;
            cyc(we, sel, d, busy, "R4 R5 R9 R11 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule